// File: doc/BRIEF.md
# DDR SDRAM Bring-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM and owns its command bus from reset until the memory can take ordinary traffic. Clock enable is held low while a parameterised settling interval runs, with the clock kept going. After that the block raises clock enable under a NOP. It then walks a fixed list of commands: precharge of every bank, a write of the extended mode register that turns the DLL on, a mode register write that resets the DLL, another precharge of every bank, a run of auto-refresh commands and, last, a mode register write with the DLL-reset bit cleared that sets the working burst length, burst order and read latency.

The gap after each command is set by the timing parameters, given in clock cycles: precharge recovery, refresh cycle time and mode-write recovery. A second counter measures the DLL lock window from the DLL-reset command. `init_done` rises when both the final mode-write recovery and the lock window have run out, and it stays high. Every cycle without a listed command carries a NOP with chip select low. While `init_done` is high, a pulse on `restart_init` reruns the tail of the list from the DLL reset onward, for use after a clock frequency change.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset release, `cke` stays low for exactly STABLE_CYC rising edges and rises on edge STABLE_CYC with a NOP on the bus. The first precharge-all follows CKE_LEAD cycles later.
- R2: Commands use {cs_n,ras_n,cas_n,we_n}: 0000 mode write, 0001 auto-refresh, 0010 precharge, 0111 NOP. Chip select is always low, and every cycle that carries no sequence command shows NOP.
- R3: The commands appear in this order: precharge-all, extended mode write, DLL-reset mode write, precharge-all, NUM_REF auto-refreshes, final mode write. No other command appears.
- R4: Each precharge-all drives addr[10]=1, ba=0 and all other address bits 0. The next command follows exactly T_RP cycles later.
- R5: The extended mode write drives ba=01 and addr=0, so addr[0]=0 enables the DLL and the drive strength is normal. The next command follows T_MRD cycles later.
- R6: The DLL-reset mode write drives ba=00, addr[8]=1, addr[6:4]=CL_CODE, addr[3]=BT_IL, addr[2:0]=BL_CODE and all other bits 0. The final mode write is the same with addr[8]=0. Each mode write is followed by at least T_MRD cycles of NOP.
- R7: Consecutive auto-refreshes, and the last refresh and the final mode write, are exactly T_RFC cycles apart.
- R8: `init_done` rises max(T_MRD cycles after the final mode write, DLL_LOCK_CYC cycles after the DLL-reset write). While it is high the bus shows only NOP.
- R9: With `init_done` high, a one-cycle `restart_init` clears `init_done` on the next edge. The DLL-reset mode write follows one cycle after that, and the sequence from R3 then runs from that command to the end, with R8 timing. While `init_done` is low, `restart_init` has no effect.
- R10: Once `cke` is high it stays high until the next reset, including across a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_init | input | 1 | Rerun the DLL reset and the lock wait; taken only while init_done is high |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, which also selects the mode or extended mode register |
| addr | output | 12 | Address lines, which carry the A10 precharge-all flag and the mode register fields |
| init_done | output | 1 | Memory ready; stays high until reset or restart |

## Verification
The checker assumes the timing parameters are valid: T_MRD is at least 2, and T_RP, T_RFC, CKE_LEAD and DLL_LOCK_CYC are at least 1. It also assumes `restart_init` is raised only when the memory banks are idle, which the block itself cannot see. The bench drives `restart_init` for single cycles only. It raises the signal once while clock enable is still low, which must be ignored, and once after `init_done` has settled. The bench uses a lock window longer than the whole command tail, so the DLL path, not the last mode-write recovery, sets the completion time.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int BA_W   = 2;
  localparam int ADDR_W = 12;

  // Encoding of {ras_n, cas_n, we_n} with chip select low
  typedef enum logic [2:0] {
    CMD_MODE = 3'b000,
    CMD_REF  = 3'b001,
    CMD_PRE  = 3'b010,
    CMD_NOP  = 3'b111
  } ddr_cmd_e;

  typedef struct packed {
    ddr_cmd_e            cmd;
    logic [BA_W-1:0]     ba;
    logic [ADDR_W-1:0]   addr;
  } ddr_word_t;

  // Mode register image: latency, burst order, length, DLL reset flag
  function automatic logic [ADDR_W-1:0] mode_image(input logic [2:0] cl_code,
                                                   input logic       bt_il,
                                                   input logic [2:0] bl_code,
                                                   input logic       dll_rst);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = bl_code;
    w[3]   = bt_il;
    w[6:4] = cl_code;
    w[8]   = dll_rst;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] prea_image();
    logic [ADDR_W-1:0] w;
    w     = '0;
    w[10] = 1'b1;
    return w;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= W'(RST_VAL);
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom import ddr_init_pkg::*; #(
  parameter int         SW       = 3,
  parameter int         TW       = 8,
  parameter int         CKE_LEAD = 1,
  parameter int         T_RP     = 5,
  parameter int         T_RFC    = 19,
  parameter int         T_MRD    = 2,
  parameter int         NUM_REF  = 2,
  parameter logic [2:0] CL_CODE  = 3'b101,
  parameter logic       BT_IL    = 1'b0,
  parameter logic [2:0] BL_CODE  = 3'b010
) (
  input  logic [SW-1:0] idx,
  output ddr_word_t     word,
  output logic [TW-1:0] gap
);
  localparam int REF_LO = 5;
  localparam int REF_HI = REF_LO + NUM_REF - 1;

  int i;
  assign i = int'(idx);

  always_comb begin
    word.cmd  = CMD_NOP;
    word.ba   = '0;
    word.addr = '0;
    gap       = TW'(T_MRD);
    if (i == 0) begin
      gap = TW'(CKE_LEAD);
    end else if (i == 1 || i == 4) begin
      word.cmd  = CMD_PRE;
      word.addr = prea_image();
      gap       = TW'(T_RP);
    end else if (i == 2) begin
      word.cmd = CMD_MODE;
      word.ba  = BA_W'(1);
    end else if (i == 3) begin
      word.cmd  = CMD_MODE;
      word.addr = mode_image(CL_CODE, BT_IL, BL_CODE, 1'b1);
    end else if (i >= REF_LO && i <= REF_HI) begin
      word.cmd = CMD_REF;
      gap      = TW'(T_RFC);
    end else begin
      word.cmd  = CMD_MODE;
      word.addr = mode_image(CL_CODE, BT_IL, BL_CODE, 1'b0);
    end
  end
endmodule

// File: rtl/ddr_init_cmd_drv.sv
module ddr_init_cmd_drv import ddr_init_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  ddr_word_t         word,
  input  logic              cke_set,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke                   <= 1'b0;
      {ras_n, cas_n, we_n}  <= CMD_NOP;
      ba                    <= '0;
      addr                  <= '0;
    end else begin
      cke <= cke | cke_set;
      if (issue) begin
        {ras_n, cas_n, we_n} <= word.cmd;
        ba                   <= word.ba;
        addr                 <= word.addr;
      end else begin
        {ras_n, cas_n, we_n} <= CMD_NOP;
        ba                   <= '0;
        addr                 <= '0;
      end
    end
  end

  assign cs_n = 1'b0;
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq import ddr_init_pkg::*; #(
  parameter int         STABLE_CYC   = 50000,
  parameter int         CKE_LEAD     = 1,
  parameter int         T_RP         = 5,
  parameter int         T_RFC        = 19,
  parameter int         T_MRD        = 2,
  parameter int         NUM_REF      = 2,
  parameter int         DLL_LOCK_CYC = 200,
  parameter logic [2:0] CL_CODE      = 3'b101,
  parameter logic       BT_IL        = 1'b0,
  parameter logic [2:0] BL_CODE      = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_init,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int NSTEP    = 6 + NUM_REF;
  localparam int SW       = $clog2(NSTEP);
  localparam int DLL_IDX  = 3;
  localparam int LAST_IDX = NSTEP - 1;
  localparam int TW       = $clog2(max_of4(STABLE_CYC, T_RFC, T_RP, CKE_LEAD) + 1);
  localparam int LW       = $clog2(DLL_LOCK_CYC + 1);

  logic [SW-1:0] step_q;
  logic          running_q;
  logic          done_q;
  ddr_word_t     word;
  logic [TW-1:0] gap;
  logic          tmr_zero, lock_zero;

  // Named internal events
  logic fire_evt, dll_rst_evt, seq_end_evt, restart_evt, ready_evt, cke_evt;

  assign fire_evt    = running_q && tmr_zero;
  assign dll_rst_evt = fire_evt && (step_q == SW'(DLL_IDX));
  assign seq_end_evt = fire_evt && (step_q == SW'(LAST_IDX));
  assign cke_evt     = fire_evt && (step_q == '0);
  assign restart_evt = done_q && restart_init;
  assign ready_evt   = !running_q && tmr_zero && lock_zero && !done_q;

  ddr_init_step_rom #(
    .SW(SW), .TW(TW), .CKE_LEAD(CKE_LEAD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .NUM_REF(NUM_REF), .CL_CODE(CL_CODE), .BT_IL(BT_IL),
    .BL_CODE(BL_CODE)
  ) rom_i (
    .idx(step_q), .word(word), .gap(gap)
  );

  ddr_init_timer #(.W(TW), .RST_VAL(STABLE_CYC - 1)) gap_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(fire_evt), .val(gap - 1'b1), .zero(tmr_zero)
  );

  ddr_init_timer #(.W(LW), .RST_VAL(0)) lock_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(dll_rst_evt), .val(LW'(DLL_LOCK_CYC - 1)),
    .zero(lock_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= '0;
      running_q <= 1'b1;
      done_q    <= 1'b0;
    end else if (restart_evt) begin
      step_q    <= SW'(DLL_IDX);
      running_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      if (seq_end_evt)   running_q <= 1'b0;
      else if (fire_evt) step_q    <= step_q + 1'b1;
      if (ready_evt)     done_q    <= 1'b1;
    end
  end

  ddr_init_cmd_drv drv_i (
    .clk(clk), .rst_n(rst_n), .issue(fire_evt), .word(word), .cke_set(cke_evt),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr)
  );

  assign init_done = done_q;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int T_RP  = 5,
  parameter int T_RFC = 19
) (
  input logic        clk,
  input logic        rst_n,
  input logic        restart_init,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic        init_done
);
  logic [2:0] rcw;
  logic       is_nop, is_cmd, is_pre, is_ref, is_mode;
  logic [7:0] gap_cnt;
  logic       last_pre, last_ref;

  assign rcw     = {ras_n, cas_n, we_n};
  assign is_nop  = (rcw == 3'b111);
  assign is_cmd  = !is_nop;
  assign is_pre  = (rcw == 3'b010);
  assign is_ref  = (rcw == 3'b001);
  assign is_mode = (rcw == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= 8'd0;
      last_pre <= 1'b0;
      last_ref <= 1'b0;
    end else if (is_cmd) begin
      gap_cnt  <= 8'd1;
      last_pre <= is_pre;
      last_ref <= is_ref;
    end else if (gap_cnt != 8'hFF) begin
      gap_cnt <= gap_cnt + 8'd1;
    end
  end

  a_r2_cs_low: assert property (@(posedge clk) disable iff (!rst_n) !cs_n);
  a_r1_quiet_cke_low: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> is_nop);
  a_r10_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke);
  a_r4_prea_a10: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> addr[10]);
  a_r4_trp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_pre) |-> (gap_cnt >= 8'(T_RP)));
  a_r7_trfc_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_ref) |-> (gap_cnt >= 8'(T_RFC)));
  a_r6_mrd_quiet: assert property (@(posedge clk) disable iff (!rst_n) is_mode |=> is_nop);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> is_nop);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !restart_init) |=> init_done);
  a_r9_restart_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && restart_init) |=> !init_done);
endmodule

bind ddr_init_seq ddr_init_chk #(.T_RP(T_RP), .T_RFC(T_RFC)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart_init(restart_init), .cke(cke), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
  .init_done(init_done)
);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;
  localparam int S    = 20;
  localparam int LK   = 30;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TMRD = 2;
  localparam int NREF = 2;
  localparam int LEAD = 1;
  localparam int NE   = 7;

  // {cmd(ras,cas,we)[24:22], ba[21:20], addr[19:8], gap_to_next[7:0]}
  // mode image: CL code 100 at A6:4, interleave at A3, BL code 011 at A2:0 -> 0x04B
  localparam logic [24:0] EXP [NE] = '{
    {3'b010, 2'b00, 12'h400, 8'd3},
    {3'b000, 2'b01, 12'h000, 8'd2},
    {3'b000, 2'b00, 12'h14B, 8'd2},
    {3'b010, 2'b00, 12'h400, 8'd3},
    {3'b001, 2'b00, 12'h000, 8'd5},
    {3'b001, 2'b00, 12'h000, 8'd5},
    {3'b000, 2'b00, 12'h04B, 8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_init = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [11:0] addr;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .STABLE_CYC(S), .CKE_LEAD(LEAD), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
    .NUM_REF(NREF), .DLL_LOCK_CYC(LK), .CL_CODE(3'b100), .BT_IL(1'b1),
    .BL_CODE(3'b011)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .restart_init(restart_init), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done)
  );

  int total = 0, bad = 0, cyc = 0, log_n = 0, illegal = 0;
  int cke_rise = -1, done_rise = -1;
  int log_cmd [32], log_ba [32], log_addr [32], log_cyc [32];
  logic prev_cke = 1'b0, prev_done = 1'b0;
  bit finished = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cs_n !== 1'b0) illegal++;
    else if ({ras_n, cas_n, we_n} != 3'b111) begin
      if (!({ras_n, cas_n, we_n} inside {3'b000, 3'b001, 3'b010})) illegal++;
      if (log_n < 32) begin
        log_cmd[log_n]  = int'({ras_n, cas_n, we_n});
        log_ba[log_n]   = int'(ba);
        log_addr[log_n] = int'(addr);
        log_cyc[log_n]  = cyc;
      end
      log_n++;
    end
    if (cke && !prev_cke) cke_rise = cyc;
    if (init_done && !prev_done) done_rise = cyc;
    prev_cke  = cke;
    prev_done = init_done;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [24:0] e);
    if (e[24:22] == 3'b010) return "R4";
    if (e[24:22] == 3'b001) return "R7";
    if (e[21:20] == 2'b01)  return "R5";
    return "R6";
  endfunction

  task automatic walk(input int base, input int first);
    for (int i = first; i < NE; i++) begin
      int j;
      j = base + i - first;
      chk("R3", "command", log_cmd[j], int'(EXP[i][24:22]));
      chk(tag_of(EXP[i]), "bank", log_ba[j], int'(EXP[i][21:20]));
      chk(tag_of(EXP[i]), "address", log_addr[j], int'(EXP[i][19:8]));
      if (i < NE - 1)
        chk(tag_of(EXP[i]), "spacing", log_cyc[j+1] - log_cyc[j], int'(EXP[i][7:0]));
    end
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!init_done && n < 2000) begin tick(); n++; end
    chk("R8", "done reached", int'(init_done), 1);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    int base, rc, expect_done;
    repeat (3) tick();
    chk("R1", "cke in reset", int'(cke), 0);
    chk("R2", "bus in reset", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
    chk("R8", "done in reset", int'(init_done), 0);
    rst_n = 1'b1;
    while (cyc < 5) tick();
    restart_init = 1'b1;   // R9: must be ignored while not done
    tick();
    restart_init = 1'b0;
    chk("R1", "cke still low", int'(cke), 0);
    wait_done();
    chk("R1", "cke rise edge", cke_rise, S);
    chk("R1", "first precharge", log_cyc[0], S + LEAD);
    chk("R3", "command count", log_n, NE);
    walk(0, 0);
    expect_done = imax(log_cyc[2] + LK, log_cyc[6] + TMRD);
    chk("R8", "done time", done_rise, expect_done);
    chk("R8", "done time abs", done_rise, 56);
    repeat (10) tick();
    chk("R8", "done held", int'(init_done), 1);
    chk("R8", "quiet when done", log_n, NE);
    chk("R10", "cke held", int'(cke), 1);

    base = log_n;
    rc = cyc;
    restart_init = 1'b1;
    tick();
    restart_init = 1'b0;
    chk("R9", "done drops", int'(init_done), 0);
    wait_done();
    chk("R9", "restart command count", log_n - base, NE - 2);
    chk("R9", "dll reset timing", log_cyc[base], rc + 2);
    walk(base, 2);
    chk("R9", "restart done time", done_rise, log_cyc[base] + LK);
    chk("R10", "cke after restart", int'(cke), 1);
    chk("R2", "illegal bus cycles", illegal, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule